// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a register-mapped general-purpose I/O port with a parameterized number of pins (16 by default). A host reaches it through a plain synchronous register bus: one write strobe, a word address, write data and registered read data. On the pin side it presents an input vector, a drive vector and a per-pin output-enable vector, which the pad ring around it turns into real bidirectional pins.

Two registers do all the work. The direction register holds a 2-bit code per pin. The code selects input, output, or an unconfigured state in which the pin is neither driven nor read. The data register holds the values to drive. Reading it merges the synchronized live pin levels of the input pins with the values driven on the output pins. A change of direction takes effect at once on the drive, using whatever the data register already holds.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction and data registers are zero, every bit of `pin_oe` and `pin_out` is 0, and reads of both registers return 0 whatever `pin_in` carries.
- R2: Direction code 2 in the field of pin i (bits [2i+1:2i] of the direction register, address 0) makes pin i an input: its `pin_oe` bit is 0 and a data read reports its synchronized `pin_in` level in bit i.
- R3: Direction codes 1 and 3 make pin i an output: its `pin_oe` bit is 1, `pin_out[i]` equals bit i of the data register, and a data read reports that driven value.
- R4: Direction code 0 leaves pin i unconfigured: `pin_oe[i]` and `pin_out[i]` are 0 and bit i of a data read is 0, whatever `pin_in[i]` and the data register hold.
- R5: A direction write rebuilds the drive at once: from the next cycle `pin_out` equals the data register bits stored earlier (including bits written while the pin was not an output) ANDed with the new output set.
- R6: A data write (address 1, low `PIN_COUNT` bits of `bus_wdata`) leaves `pin_oe` unchanged and from the next cycle drives `pin_out` with the written value ANDed with the output set.
- R7: A read returns data one clock after the address is presented; a data read gives (synchronized inputs AND input set) OR (data register AND output set) in the low bits and zeros above; a direction read gives the direction register as last written.
- R8: `pin_in` passes through a two-flop synchronizer: a change first appears in `bus_rdata` at the third rising edge after it, with the data address held.
- R9: Addresses other than 0 and 1 read as zero, and writes to them change neither register nor any pin output.
- R10: A pin whose `pin_oe` bit is 0 always has its `pin_out` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address: 0 direction, 1 data |
| bus_wdata | input | 2*PIN_COUNT | Write data |
| bus_rdata | output | 2*PIN_COUNT | Read data, registered, one cycle after the address |
| pin_in | input | PIN_COUNT | Asynchronous levels sampled from the pins |
| pin_out | output | PIN_COUNT | Drive values toward the pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable |

## Verification
The bench walks every pin through all four direction codes and then runs whole-port mixed patterns, with live inputs set opposite to the stored data so that a read taken from the wrong source shows at once; a design that treated code 3 as unconfigured or code 0 as an input would report or drive the wrong bit. It stores data while pins are unconfigured and then turns them into outputs, which catches a design that clears or drops those stored bits. It measures the synchronizer latency edge by edge, so a missing or an extra stage moves the read value by a cycle, and it writes to the unused addresses to expose any decoding that aliases them onto a real register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Per-pin direction field encoding
  typedef enum logic [1:0] {
    DIR_OFF    = 2'd0,
    DIR_OUT_LO = 2'd1,
    DIR_IN     = 2'd2,
    DIR_OUT_HI = 2'd3
  } dir_code_e;

  localparam int CFG_ADDR    = 0;
  localparam int DAT_ADDR    = 1;
  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/gpio_dir_decode.sv
module gpio_dir_decode #(
  parameter int PIN_COUNT = 16
) (
  input  logic [2*PIN_COUNT-1:0] cfg,
  output logic [PIN_COUNT-1:0]   in_mask,
  output logic [PIN_COUNT-1:0]   out_mask
);

  for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
    gpio_pkg::dir_code_e code;
    assign code        = gpio_pkg::dir_code_e'(cfg[2*g +: 2]);
    assign in_mask[g]  = (code == gpio_pkg::DIR_IN);
    assign out_mask[g] = (code == gpio_pkg::DIR_OUT_LO) || (code == gpio_pkg::DIR_OUT_HI);
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PIN_COUNT = 16,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_COUNT-1:0] d,
  output logic [PIN_COUNT-1:0] q
);

  logic [STAGES-1:0][PIN_COUNT-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux #(
  parameter int PIN_COUNT = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [2*PIN_COUNT-1:0] cfg_q,
  input  logic [PIN_COUNT-1:0]   dat_q,
  input  logic [PIN_COUNT-1:0]   in_mask,
  input  logic [PIN_COUNT-1:0]   out_mask,
  input  logic [PIN_COUNT-1:0]   pins_sync,
  output logic [2*PIN_COUNT-1:0] rdata
);

  localparam int W = 2*PIN_COUNT;
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(gpio_pkg::CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(gpio_pkg::DAT_ADDR);

  logic [PIN_COUNT-1:0] merged;
  logic [W-1:0]         rdata_d;

  assign merged = (pins_sync & in_mask) | (dat_q & out_mask);

  always_comb begin
    rdata_d = '0;
    if (addr == A_CFG)      rdata_d = cfg_q;
    else if (addr == A_DAT) rdata_d = {{PIN_COUNT{1'b0}}, merged};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_d;
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int PIN_COUNT = 16,
  parameter int ADDR_W    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [2*PIN_COUNT-1:0] bus_wdata,
  output logic [2*PIN_COUNT-1:0] bus_rdata,
  input  logic [PIN_COUNT-1:0]   pin_in,
  output logic [PIN_COUNT-1:0]   pin_out,
  output logic [PIN_COUNT-1:0]   pin_oe
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(gpio_pkg::CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(gpio_pkg::DAT_ADDR);

  logic [2*PIN_COUNT-1:0] cfg_q;
  logic [PIN_COUNT-1:0]   dat_q;
  logic [PIN_COUNT-1:0]   in_mask, out_mask, pins_sync;

  // Direction and data registers; data keeps every written bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      dat_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CFG) cfg_q <= bus_wdata;
      if (bus_addr == A_DAT) dat_q <= bus_wdata[PIN_COUNT-1:0];
    end
  end

  gpio_dir_decode #(.PIN_COUNT(PIN_COUNT)) u_decode (
    .cfg      (cfg_q),
    .in_mask  (in_mask),
    .out_mask (out_mask)
  );

  gpio_in_sync #(.PIN_COUNT(PIN_COUNT), .STAGES(gpio_pkg::SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  gpio_read_mux #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_rmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .cfg_q     (cfg_q),
    .dat_q     (dat_q),
    .in_mask   (in_mask),
    .out_mask  (out_mask),
    .pins_sync (pins_sync),
    .rdata     (bus_rdata)
  );

  assign pin_oe  = out_mask;
  assign pin_out = dat_q & out_mask;

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int PIN_COUNT = 16,
  parameter int ADDR_W    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [2*PIN_COUNT-1:0] bus_wdata,
  input logic [2*PIN_COUNT-1:0] bus_rdata,
  input logic [PIN_COUNT-1:0]   pin_out,
  input logic [PIN_COUNT-1:0]   pin_oe
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(gpio_pkg::CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(gpio_pkg::DAT_ADDR);

  logic undef_addr;
  assign undef_addr = (bus_addr != A_CFG) && (bus_addr != A_DAT);

  AST_NO_DRIVE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R10

  AST_DATA_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DAT) |=> pin_out == ($past(bus_wdata[PIN_COUNT-1:0]) & pin_oe)); // R6

  AST_DATA_WRITE_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_DAT) |=> $stable(pin_oe)); // R6

  AST_UNDEF_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && undef_addr) |=> ($stable(pin_oe) && $stable(pin_out))); // R9

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    undef_addr |=> bus_rdata == '0); // R9

  AST_DATA_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DAT) |=> bus_rdata[2*PIN_COUNT-1:PIN_COUNT] == '0); // R7

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;
  localparam int P  = 16;
  localparam int AW = 2;
  localparam int W  = 2*P;

  logic          clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [P-1:0]  pin_in = '0;
  logic [P-1:0]  pin_out, pin_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.PIN_COUNT(P), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  // Model: codes 1 and 3 are outputs, code 2 is input, code 0 is neither
  function automatic logic [P-1:0] m_out(input logic [W-1:0] cfg);
    for (int i = 0; i < P; i++) m_out[i] = cfg[2*i +: 2] == 2'd1 || cfg[2*i +: 2] == 2'd3;
  endfunction
  function automatic logic [P-1:0] m_in(input logic [W-1:0] cfg);
    for (int i = 0; i < P; i++) m_in[i] = cfg[2*i +: 2] == 2'd2;
  endfunction

  task automatic apply(input string tag, input logic [W-1:0] cfg, input logic [P-1:0] dat, input logic [P-1:0] pins);
    logic [W-1:0] r;
    wr(AW'(0), cfg);
    wr(AW'(1), W'(dat));
    pin_in = pins;
    repeat (2) @(posedge clk);
    rd(AW'(1), r);
    check({tag, " R2 R3 R4 pin_oe"}, W'(pin_oe), W'(m_out(cfg)));
    check({tag, " R3 R10 pin_out"}, W'(pin_out), W'(dat & m_out(cfg)));
    check({tag, " R7 data read"}, r, W'((pins & m_in(cfg)) | (dat & m_out(cfg))));
    rd(AW'(0), r);
    check({tag, " R7 dir read"}, r, cfg);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    // R1: reset state with live inputs high
    pin_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check("R1 pin_oe after reset", W'(pin_oe), '0);
    check("R1 pin_out after reset", W'(pin_out), '0);
    repeat (3) @(posedge clk);
    rd(AW'(0), r); check("R1 dir read after reset", r, '0);
    rd(AW'(1), r); check("R1 R4 data read after reset", r, '0);

    // Per-pin sweep over all four codes, other pins unconfigured
    for (int i = 0; i < P; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic [P-1:0] d;
        d = ((i + c) % 2 == 1) ? '1 : '0;
        apply($sformatf("pin%0d code%0d", i, c), W'(c) << (2*i), d, ~d);
      end
    end

    // Mixed whole-port patterns
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] cfg;
      for (int i = 0; i < P; i++) cfg[2*i +: 2] = 2'((i + k) % 4);
      apply($sformatf("mix%0d a", k), cfg, 16'hA5C3, 16'h5A3C);
      apply($sformatf("mix%0d b", k), cfg, 16'h0F0F, 16'h0FF0);
    end

    // R5 and R6: data stored while unconfigured, then pins become outputs
    wr(AW'(0), '0);
    wr(AW'(1), W'(16'hBEEF));
    check("R6 data write with no outputs", W'(pin_out), '0);
    check("R6 data write keeps pin_oe", W'(pin_oe), '0);
    wr(AW'(0), 32'h5555_5555);
    check("R5 dir write to all code1 drives stored data", W'(pin_out), W'(16'hBEEF));
    wr(AW'(0), 32'hFFFF_0000);
    check("R5 dir write to upper code3", W'(pin_out), W'(16'hBE00));
    wr(AW'(0), 32'hAAAA_AAAA);
    check("R5 dir write to all inputs", W'(pin_out), '0);

    // R8: synchronizer latency with all pins inputs
    wr(AW'(1), '0);
    pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_addr = AW'(1);
    pin_in = 16'h1234;
    @(posedge clk); #1; check("R8 edge1 old value", bus_rdata, '0);
    @(posedge clk); #1; check("R8 edge2 old value", bus_rdata, '0);
    @(posedge clk); #1; check("R8 edge3 new value", bus_rdata, W'(16'h1234));

    // R9: undefined addresses
    wr(AW'(0), 32'h0000_5A6D);
    wr(AW'(1), W'(16'h00C5));
    wr(AW'(2), '1);
    wr(AW'(3), 32'h1234_5678);
    check("R9 pin_oe after undefined writes", W'(pin_oe), W'(m_out(32'h0000_5A6D)));
    check("R9 pin_out after undefined writes", W'(pin_out), W'(16'h00C5 & m_out(32'h0000_5A6D)));
    rd(AW'(0), r); check("R9 dir reg untouched", r, 32'h0000_5A6D);
    rd(AW'(2), r); check("R9 read addr2", r, '0);
    rd(AW'(3), r); check("R9 read addr3", r, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule